// File: doc/BRIEF.md
# Readout Node Run-Control Sequencer

This block keeps track of where a detector readout node is in its operating lifecycle. Software or a higher-level controller issues single-cycle transition requests: power up, power down, begin and finish configuration, start and stop a run, and open and close a bunch train. A status bit travels with the power-up request and says whether power-up succeeded. The sequencer accepts only the requests that are legal in the current state. It rejects every other request with a one-cycle error pulse and leaves its state untouched.

The outputs report the current state as a 3-bit code, a busy flag while configuration is in progress, a run-active flag, an in-train flag, and a count of the bunch trains opened since the most recent run start. All outputs are registered. A request sampled on a rising clock edge shows its effect on the outputs just after that same edge.

Top module: `rdo_runctl`

## Requirements
- R1: The state code is Dead=0, Ready=1, Configured=2, Running=3, InBunchTrain=4. After reset the code is 0, all flags are low and the train count is 0.
- R2: In Dead, a power-up request moves to Ready when `pwr_up_ok` is 1. When `pwr_up_ok` is 0 the state stays Dead and no error is raised.
- R3: In Ready with `cfg_busy` low, a configuration-begin request sets `cfg_busy` and the state stays Ready. A configuration-done request while busy moves to Configured and clears `cfg_busy`.
- R4: A run-start request in Configured moves to Running and sets `run_active`. A run-stop request in Running returns to Configured and clears `run_active`.
- R5: A train-open request in Running moves to InBunchTrain and sets `in_train`, with `run_active` staying high. A train-close request returns to Running.
- R6: A power-down request in Dead, Ready (busy or idle), Configured or Running moves to Dead and clears every flag, with no error.
- R7: A power-down request in InBunchTrain raises no error and leaves the state unchanged. The next train-close request then moves to Dead instead of Running.
- R8: A request that is not legal in the current state leaves the state, `cfg_busy` and the train count unchanged. `err_pulse` goes high for exactly the one cycle after that request.
- R9: Two or more request inputs high in the same cycle count as one illegal request.
- R10: The train count clears to 0 on run start and increments on every train open. It wraps modulo 2^CNT_W and holds its value at all other times, including after run stop.
- R11: Outputs change only on the clock edge that samples a request, never combinationally from the request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up_req | input | 1 | Power-up request pulse |
| pwr_up_ok | input | 1 | Power-up outcome, sampled with pwr_up_req (1 = success) |
| pwr_down_req | input | 1 | Power-down request pulse |
| cfg_begin_req | input | 1 | Configuration begin request pulse |
| cfg_done_req | input | 1 | Configuration done request pulse |
| run_start_req | input | 1 | Run start request pulse |
| run_stop_req | input | 1 | Run stop request pulse |
| train_open_req | input | 1 | Bunch-train start request pulse |
| train_close_req | input | 1 | Bunch-train end request pulse |
| state_code | output | 3 | Current state code (see R1) |
| cfg_busy | output | 1 | Configuration in progress |
| run_active | output | 1 | State is Running or InBunchTrain |
| in_train | output | 1 | State is InBunchTrain |
| err_pulse | output | 1 | One-cycle pulse after an illegal request |
| train_count | output | CNT_W | Bunch trains opened since the last run start |

## Verification
The bench builds the sequencer with `CNT_W` = 4. With that width the counter wraps after only sixteen train openings, so a directed loop of train open and close pairs crosses the wrap point. The random phase can also reach it when runs grow long. The default width would need 65536 trains to show the same rollover. The random phase fires single, absent and multiple requests at every state, including the deferred power-down path, and each outcome is compared with a bench reference model.

// File: rtl/rdo_runctl_pkg.sv
package rdo_runctl_pkg;

  typedef enum logic [2:0] {
    ST_DEAD       = 3'd0,
    ST_READY      = 3'd1,
    ST_CONFIGURED = 3'd2,
    ST_RUNNING    = 3'd3,
    ST_IN_TRAIN   = 3'd4
  } rc_state_e;

  localparam int unsigned N_REQ       = 8;
  localparam int unsigned RQ_PWR_UP   = 0;
  localparam int unsigned RQ_PWR_DOWN = 1;
  localparam int unsigned RQ_CFG_BEG  = 2;
  localparam int unsigned RQ_CFG_DONE = 3;
  localparam int unsigned RQ_RUN_GO   = 4;
  localparam int unsigned RQ_RUN_STOP = 5;
  localparam int unsigned RQ_TR_OPEN  = 6;
  localparam int unsigned RQ_TR_CLOSE = 7;

endpackage

// File: rtl/rdo_req_decode.sv
module rdo_req_decode
  import rdo_runctl_pkg::*;
(
  input  logic [N_REQ-1:0] req_vec,
  output logic             req_single,
  output logic             req_multi
);
  localparam int unsigned CW = $clog2(N_REQ + 1);

  logic [CW-1:0] n_set;

  always_comb begin
    n_set = '0;
    for (int i = 0; i < N_REQ; i++) begin
      n_set = n_set + CW'(req_vec[i]);
    end
    req_single = (n_set == CW'(1));
    req_multi  = (n_set > CW'(1));
  end
endmodule

// File: rtl/rdo_next_state.sv
module rdo_next_state
  import rdo_runctl_pkg::*;
(
  input  rc_state_e        cur_state,
  input  logic             cur_busy,
  input  logic             cur_pend,
  input  logic [N_REQ-1:0] req_vec,
  input  logic             req_single,
  input  logic             req_multi,
  input  logic             pwr_ok,
  output rc_state_e        nxt_state,
  output logic             nxt_busy,
  output logic             nxt_pend,
  output logic             nxt_err,
  output logic             cnt_clr,
  output logic             cnt_inc
);
  always_comb begin
    nxt_state = cur_state;
    nxt_busy  = cur_busy;
    nxt_pend  = cur_pend;
    nxt_err   = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    if (req_multi) begin
      nxt_err = 1'b1;
    end else if (req_single) begin
      unique case (cur_state)
        ST_DEAD: begin
          if (req_vec[RQ_PWR_UP]) begin
            if (pwr_ok) nxt_state = ST_READY;
          end else if (!req_vec[RQ_PWR_DOWN]) begin
            nxt_err = 1'b1;
          end
        end
        ST_READY: begin
          if (req_vec[RQ_PWR_DOWN]) begin
            nxt_state = ST_DEAD;
            nxt_busy  = 1'b0;
          end else if (!cur_busy && req_vec[RQ_CFG_BEG]) begin
            nxt_busy = 1'b1;
          end else if (cur_busy && req_vec[RQ_CFG_DONE]) begin
            nxt_state = ST_CONFIGURED;
            nxt_busy  = 1'b0;
          end else begin
            nxt_err = 1'b1;
          end
        end
        ST_CONFIGURED: begin
          if (req_vec[RQ_PWR_DOWN]) begin
            nxt_state = ST_DEAD;
          end else if (req_vec[RQ_RUN_GO]) begin
            nxt_state = ST_RUNNING;
            cnt_clr   = 1'b1;
          end else begin
            nxt_err = 1'b1;
          end
        end
        ST_RUNNING: begin
          if (req_vec[RQ_PWR_DOWN]) begin
            nxt_state = ST_DEAD;
          end else if (req_vec[RQ_TR_OPEN]) begin
            nxt_state = ST_IN_TRAIN;
            cnt_inc   = 1'b1;
          end else if (req_vec[RQ_RUN_STOP]) begin
            nxt_state = ST_CONFIGURED;
          end else begin
            nxt_err = 1'b1;
          end
        end
        ST_IN_TRAIN: begin
          if (req_vec[RQ_PWR_DOWN]) begin
            nxt_pend = 1'b1;
          end else if (req_vec[RQ_TR_CLOSE]) begin
            nxt_state = cur_pend ? ST_DEAD : ST_RUNNING;
            nxt_pend  = 1'b0;
          end else begin
            nxt_err = 1'b1;
          end
        end
        default: begin
          nxt_state = ST_DEAD;
          nxt_busy  = 1'b0;
          nxt_pend  = 1'b0;
          nxt_err   = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/rdo_train_cnt.sv
module rdo_train_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/rdo_runctl.sv
module rdo_runctl
  import rdo_runctl_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_up_req,
  input  logic             pwr_up_ok,
  input  logic             pwr_down_req,
  input  logic             cfg_begin_req,
  input  logic             cfg_done_req,
  input  logic             run_start_req,
  input  logic             run_stop_req,
  input  logic             train_open_req,
  input  logic             train_close_req,
  output logic [2:0]       state_code,
  output logic             cfg_busy,
  output logic             run_active,
  output logic             in_train,
  output logic             err_pulse,
  output logic [CNT_W-1:0] train_count
);
  logic [N_REQ-1:0] req_vec;
  logic             req_single, req_multi;
  rc_state_e        state_q, nxt_state;
  logic             pend_q, nxt_busy, nxt_pend, nxt_err, cnt_clr, cnt_inc;

  always_comb begin
    req_vec              = '0;
    req_vec[RQ_PWR_UP]   = pwr_up_req;
    req_vec[RQ_PWR_DOWN] = pwr_down_req;
    req_vec[RQ_CFG_BEG]  = cfg_begin_req;
    req_vec[RQ_CFG_DONE] = cfg_done_req;
    req_vec[RQ_RUN_GO]   = run_start_req;
    req_vec[RQ_RUN_STOP] = run_stop_req;
    req_vec[RQ_TR_OPEN]  = train_open_req;
    req_vec[RQ_TR_CLOSE] = train_close_req;
  end

  rdo_req_decode u_dec (
    .req_vec    (req_vec),
    .req_single (req_single),
    .req_multi  (req_multi)
  );

  rdo_next_state u_nxt (
    .cur_state  (state_q),
    .cur_busy   (cfg_busy),
    .cur_pend   (pend_q),
    .req_vec    (req_vec),
    .req_single (req_single),
    .req_multi  (req_multi),
    .pwr_ok     (pwr_up_ok),
    .nxt_state  (nxt_state),
    .nxt_busy   (nxt_busy),
    .nxt_pend   (nxt_pend),
    .nxt_err    (nxt_err),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc)
  );

  rdo_train_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .count (train_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_DEAD;
      cfg_busy   <= 1'b0;
      pend_q     <= 1'b0;
      err_pulse  <= 1'b0;
      run_active <= 1'b0;
      in_train   <= 1'b0;
    end else begin
      state_q    <= nxt_state;
      cfg_busy   <= nxt_busy;
      pend_q     <= nxt_pend;
      err_pulse  <= nxt_err;
      run_active <= (nxt_state == ST_RUNNING) || (nxt_state == ST_IN_TRAIN);
      in_train   <= (nxt_state == ST_IN_TRAIN);
    end
  end

  assign state_code = state_q;
endmodule

// File: rtl/rdo_runctl_chk.sv
module rdo_runctl_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       state_code,
  input logic             cfg_busy,
  input logic             run_active,
  input logic             in_train,
  input logic             err_pulse,
  input logic [CNT_W-1:0] train_count
);
  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst)
    state_code <= 3'd4); // R1
  AST_BUSY_IN_READY: assert property (@(posedge clk) disable iff (rst)
    cfg_busy |-> state_code == 3'd1); // R3
  AST_TRAIN_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    in_train |-> run_active); // R5
  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> ($stable(state_code) && $stable(cfg_busy) && $stable(train_count))); // R8
  AST_RUN_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd3 && $past(state_code) == 3'd2) |-> train_count == '0); // R10
  AST_OPEN_BUMPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd4 && $past(state_code) == 3'd3) |->
      train_count == $past(train_count) + CNT_W'(1)); // R10
  AST_TRAIN_EXIT: assert property (@(posedge clk) disable iff (rst)
    ($past(state_code) == 3'd4 && state_code != 3'd4) |->
      (state_code == 3'd3 || state_code == 3'd0)); // R7
endmodule

bind rdo_runctl rdo_runctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .state_code  (state_code),
  .cfg_busy    (cfg_busy),
  .run_active  (run_active),
  .in_train    (in_train),
  .err_pulse   (err_pulse),
  .train_count (train_count)
);

// File: tb/test_rdo_runctl.sv
`timescale 1ns/1ps
module test_rdo_runctl;
  localparam int unsigned CW = 4;
  // request bit positions used by the bench
  localparam logic [7:0] Q_UP = 8'h01, Q_DN = 8'h02, Q_CB = 8'h04, Q_CD = 8'h08,
                         Q_RS = 8'h10, Q_RP = 8'h20, Q_TO = 8'h40, Q_TC = 8'h80;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] rq = '0;
  logic ok = 1'b0;
  logic [2:0] state_code;
  logic cfg_busy, run_active, in_train, err_pulse;
  logic [CW-1:0] train_count;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model
  int m_st = 0;
  bit m_busy = 0, m_pend = 0, m_err = 0;
  logic [CW-1:0] m_cnt = '0;

  always #4 clk = ~clk;

  rdo_runctl #(.CNT_W(CW)) i_rdo_runctl (
    .clk(clk), .rst(rst),
    .pwr_up_req(rq[0]), .pwr_up_ok(ok), .pwr_down_req(rq[1]),
    .cfg_begin_req(rq[2]), .cfg_done_req(rq[3]),
    .run_start_req(rq[4]), .run_stop_req(rq[5]),
    .train_open_req(rq[6]), .train_close_req(rq[7]),
    .state_code(state_code), .cfg_busy(cfg_busy), .run_active(run_active),
    .in_train(in_train), .err_pulse(err_pulse), .train_count(train_count)
  );

  function automatic int ones8(logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic model(logic [7:0] v, logic pok);
    m_err = 0;
    if (ones8(v) > 1) m_err = 1;
    else if (ones8(v) == 1) begin
      case (m_st)
        0: if (v == Q_UP) begin if (pok) m_st = 1; end
           else if (v != Q_DN) m_err = 1;
        1: if (v == Q_DN) begin m_st = 0; m_busy = 0; end
           else if (!m_busy && v == Q_CB) m_busy = 1;
           else if (m_busy && v == Q_CD) begin m_st = 2; m_busy = 0; end
           else m_err = 1;
        2: if (v == Q_DN) m_st = 0;
           else if (v == Q_RS) begin m_st = 3; m_cnt = '0; end
           else m_err = 1;
        3: if (v == Q_DN) m_st = 0;
           else if (v == Q_TO) begin m_st = 4; m_cnt = m_cnt + CW'(1); end
           else if (v == Q_RP) m_st = 2;
           else m_err = 1;
        default: if (v == Q_DN) m_pend = 1;
           else if (v == Q_TC) begin m_st = m_pend ? 0 : 3; m_pend = 0; end
           else m_err = 1;
      endcase
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "state", int'(state_code), m_st);
    chk(tag, "busy", int'(cfg_busy), int'(m_busy));
    chk(tag, "run_active", int'(run_active), int'(m_st == 3 || m_st == 4));
    chk(tag, "in_train", int'(in_train), int'(m_st == 4));
    chk(tag, "err", int'(err_pulse), int'(m_err));
    chk(tag, "count", int'(train_count), int'(m_cnt));
  endtask

  // called just after a falling edge
  task automatic step(logic [7:0] v, logic pok, string tag);
    int old_st = m_st;
    rq = v; ok = pok;
    #1;
    chk("R11", "state before edge", int'(state_code), old_st);
    @(posedge clk); #1;
    model(v, pok);
    compare_all(tag);
    rq = '0; ok = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int r;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    compare_all("R1");
    step(Q_UP, 1'b0, "R2");
    step(Q_UP, 1'b1, "R2");
    step(Q_RS, 1'b0, "R8");
    step('0, 1'b0, "R8");
    step(Q_CB, 1'b0, "R3");
    step(Q_CB, 1'b0, "R8");
    step(Q_CD, 1'b0, "R3");
    step(Q_RS | Q_DN, 1'b0, "R9");
    step(Q_RS, 1'b0, "R4");
    step(Q_TO, 1'b0, "R5");
    step(Q_TC, 1'b0, "R5");
    for (int i = 0; i < 20; i++) begin
      step(Q_TO, 1'b0, "R10");
      step(Q_TC, 1'b0, "R10");
    end
    step(Q_RP, 1'b0, "R4");
    step(Q_RS, 1'b0, "R10");
    step(Q_TO, 1'b0, "R10");
    step(Q_DN, 1'b0, "R7");
    step(Q_RP, 1'b0, "R8");
    step(Q_DN, 1'b0, "R7");
    step(Q_TC, 1'b0, "R7");
    step(Q_DN, 1'b0, "R6");
    step(Q_UP, 1'b1, "R2");
    step(Q_CB, 1'b0, "R3");
    step(Q_DN, 1'b0, "R6");
    step(Q_UP, 1'b1, "R2");
    step(Q_CB, 1'b0, "R3");
    step(Q_CD, 1'b0, "R3");
    step(Q_RS, 1'b0, "R4");
    step(Q_DN, 1'b0, "R6");
    for (int i = 0; i < 1500; i++) begin
      r = int'($urandom % 20);
      if (r == 0) v = '0;
      else if (r < 18) begin
        v = 8'(1) << ($urandom % 8);
        if (v == Q_DN) v = 8'(1) << ($urandom % 8);
      end else begin
        v = 8'($urandom);
        if (ones8(v) < 2) v = v | 8'h41;
      end
      step(v, 1'(($urandom % 4) != 0), "R8");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule